// File: doc/BRIEF.md
# Auto-Increment Register Bank on a Two-Wire Serial Bus

This block is a target device on a two-wire serial bus (I2C). It holds a small bank of byte-wide registers, ten by default, and one pointer into that bank. The pointer keeps its value from one transaction to the next. It advances after every data byte, whether the byte was written or read.

A controller writes by sending the device address with the direction bit clear. It follows with a register index, which loads the pointer, and then any number of data bytes. These land at consecutive registers. After the last register the pointer goes back to register 0.

There are two ways to read. A current-pointer read addresses the device with the direction bit set and streams out bytes, starting at the stored pointer. A random read first sends a write header that only loads the pointer. It then issues a repeated start and a read header. Both bus lines are sampled through synchronisers on the system clock. The device drives SDA only through an open-drain enable.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset every register reads 0x00, the pointer is 0 and `sda_oe` is 0.
- R2: The first byte after a start is the 7-bit device address (MSB first), followed by a direction bit in bit 0: 1 = read, 0 = write. When the address equals `DEV_ADDR`, the device pulls SDA low in the ninth clock.
- R3: A non-matching address byte gets no acknowledge. The device then ignores all bus traffic until the next start. Neither registers nor pointer change.
- R4: In a write, the byte after the address loads the pointer. Each later byte is stored at the pointer, after which the pointer advances by one. Every one of these bytes is acknowledged.
- R5: A loaded register index of `NREGS` or more is reduced modulo `NREGS`.
- R6: The pointer advances from `NREGS-1` to 0, both in write bursts and in read bursts.
- R7: A read returns the byte at the pointer, MSB first, and advances the pointer once per byte sent. A read with no preceding index therefore continues from the last access plus one.
- R8: A repeated start restarts address matching and leaves the pointer unchanged, so a random read returns data from the loaded index.
- R9: A controller acknowledge (SDA low in the ninth clock) after a read byte makes the device send the next byte. A non-acknowledge makes it release SDA and ignore clocks until a start or a stop.
- R10: `sda_oe` changes only while SCL is low. A stop always returns the device to idle with SDA released.

Parameters: `DEV_ADDR` (7-bit device address), `NREGS` (bank size), `SYNC_STAGES` (synchroniser depth, at least 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | 1 = pull SDA low; 0 = release it |

## Verification
Several properties are checked on every cycle. The SDA enable changes only while the raw SCL is low, and it stays released in idle. Start and stop detections reset the protocol engine, and a start leaves the pointer alone. The pointer stays inside the bank, moves only on a load or an advance, and advances from the top register to zero.

Other behaviour only the bench scenarios can show. These are the data values returned and the acknowledge levels on the wire. They also include the modulo reduction of a large index and the bursts that cross the end of the bank. Finally, they cover the silence after a non-matching address or a read non-acknowledge, and the register contents after a mid-run reset.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,  // ignoring the bus until a start
    ST_ADDR,  // shifting in the address byte
    ST_AACK,  // acknowledging the address
    ST_SUB,   // shifting in the register index
    ST_SACK,  // acknowledging the index
    ST_WR,    // shifting in a data byte
    ST_WACK,  // acknowledging a data byte
    ST_RD,    // shifting out a data byte
    ST_MACK   // waiting for the controller's acknowledge
  } rs_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  // one stage beyond the synchroniser keeps the previous sample for edges
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] scl_q, sda_q, scl_d, sda_d;
  logic          scl_now, scl_old, sda_old;

  always_comb begin
    scl_d = {scl_q[LAST-1:0], scl_i};
    sda_d = {sda_q[LAST-1:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  always_comb begin
    scl_now  = scl_q[LAST-1];
    scl_old  = scl_q[LAST];
    sda_s    = sda_q[LAST-1];
    sda_old  = sda_q[LAST];
    scl_rise = scl_now & ~scl_old;
    scl_fall = ~scl_now & scl_old;
    start_ev = scl_now & scl_old & sda_old & ~sda_s;
    stop_ev  = scl_now & scl_old & ~sda_old & sda_s;
  end
endmodule

// File: rtl/i2c_rs_bank.sv
module i2c_rs_bank #(
  parameter int NREGS = 10,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_en,
  input  logic [AW-1:0]               ld_val,
  input  logic                        inc_en,
  input  logic                        wr_en,
  input  logic [i2c_rs_pkg::BYTE_W-1:0] wr_data,
  output logic [i2c_rs_pkg::BYTE_W-1:0] rd_data,
  output logic [AW-1:0]               ptr
);
  import i2c_rs_pkg::*;

  localparam logic [AW-1:0] TOP_IDX = AW'(NREGS - 1);

  logic [BYTE_W-1:0] regs [NREGS];
  logic [AW-1:0]     ptr_n;

  always_comb begin
    ptr_n = ptr;
    if (ld_en)
      ptr_n = ld_val;
    else if (inc_en)
      ptr_n = (ptr == TOP_IDX) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (ld_en || inc_en)
      ptr <= ptr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[ptr] <= wr_data;
    end
  end

  assign rd_data = regs[ptr];
endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NREGS    = 10,
  parameter int         AW       = $clog2(NREGS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sda_s,
  input  logic                          scl_rise,
  input  logic                          scl_fall,
  input  logic                          start_ev,
  input  logic                          stop_ev,
  input  logic [i2c_rs_pkg::BYTE_W-1:0] rd_data,
  output logic                          ld_en,
  output logic [AW-1:0]                 ld_val,
  output logic                          inc_en,
  output logic                          wr_en,
  output logic [i2c_rs_pkg::BYTE_W-1:0] wr_data,
  output logic                          sda_oe,
  output i2c_rs_pkg::rs_state_e         state
);
  import i2c_rs_pkg::*;

  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  rs_state_e         state_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              oe_n;

  assign wr_data = sh;
  assign ld_val  = AW'(sh % NREGS);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    sh_n    = sh;
    oe_n    = sda_oe;
    ld_en   = 1'b0;
    inc_en  = 1'b0;
    wr_en   = 1'b0;

    if (start_ev) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (stop_ev) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WR: begin
          if (scl_rise && cnt != FULL) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            cnt_n = '0;
            if (state == ST_ADDR) begin
              if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                state_n = ST_AACK;
                oe_n    = 1'b1;
              end else begin
                state_n = ST_IDLE;
              end
            end else if (state == ST_SUB) begin
              ld_en   = 1'b1;
              state_n = ST_SACK;
              oe_n    = 1'b1;
            end else begin
              wr_en   = 1'b1;
              inc_en  = 1'b1;
              state_n = ST_WACK;
              oe_n    = 1'b1;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (sh[0]) begin
              inc_en  = 1'b1;
              sh_n    = rd_data;
              oe_n    = ~rd_data[BYTE_W-1];
              cnt_n   = CW'(1);
              state_n = ST_RD;
            end else begin
              oe_n    = 1'b0;
              cnt_n   = '0;
              state_n = ST_SUB;
            end
          end
        end
        ST_SACK, ST_WACK: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            cnt_n   = '0;
            state_n = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt == FULL) begin
              oe_n    = 1'b0;
              state_n = ST_MACK;
            end else begin
              oe_n  = ~sh[BYTE_W-2];
              sh_n  = {sh[BYTE_W-2:0], 1'b0};
              cnt_n = cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_s) begin
            state_n = ST_IDLE;
          end else if (scl_fall) begin
            inc_en  = 1'b1;
            sh_n    = rd_data;
            oe_n    = ~rd_data[BYTE_W-1];
            cnt_n   = CW'(1);
            state_n = ST_RD;
          end
        end
        default: begin
          state_n = ST_IDLE;
          oe_n    = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      sda_oe <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      sda_oe <= oe_n;
    end
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NREGS       = 10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import i2c_rs_pkg::*;

  localparam int AW = $clog2(NREGS);

  logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              ld_en, inc_en, wr_en;
  logic [AW-1:0]     ld_val, ptr;
  logic [BYTE_W-1:0] rd_data, wr_data;
  rs_state_e         state;

  i2c_rs_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_rs_fsm #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .ld_en(ld_en), .ld_val(ld_val), .inc_en(inc_en),
    .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe), .state(state)
  );

  i2c_rs_bank #(.NREGS(NREGS), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
    .inc_en(inc_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ptr(ptr)
  );
endmodule

// File: rtl/i2c_rs_chk.sv
module i2c_rs_chk #(
  parameter int NREGS = 10,
  parameter int AW    = $clog2(NREGS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic                  start_ev,
  input logic                  stop_ev,
  input logic                  ld_en,
  input logic                  inc_en,
  input logic [AW-1:0]         ptr,
  input i2c_rs_pkg::rs_state_e state
);
  import i2c_rs_pkg::*;

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE) && !sda_oe);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R8
  rstart_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_ADDR) && $stable(ptr));

  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < AW'(NREGS));

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !ld_en && ptr == AW'(NREGS - 1)) |=> (ptr == '0));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !ld_en) |=> $stable(ptr));
endmodule

bind i2c_regbank_slave i2c_rs_chk #(.NREGS(NREGS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_ev(start_ev), .stop_ev(stop_ev), .ld_en(ld_en), .inc_en(inc_en),
  .ptr(ptr), .state(state)
);

// File: tb/sim_i2c_regbank_slave.sv
`timescale 1ns/1ps
module sim_i2c_regbank_slave;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int N = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  wire  sda_line;

  assign sda_line = !(m_low || sda_oe);

  always #2.5 clk = ~clk;

  i2c_regbank_slave #(.DEV_ADDR(DEV), .NREGS(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mdl [N];
  int         mptr;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops a received byte against the expected one
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(g == e, t, g, e);
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq();
    scl = 1'b1; wq();
    m_low = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq();
    scl = 1'b1; wq();
    m_low = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq();
      scl = 1'b1; wq();
      scl = 1'b0;
    end
    m_low = 1'b0; wq();
    scl = 1'b1; wq();
    ack = !sda_line;
    scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack);
    logic [7:0] b;
    b = '0;
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wq();
      scl = 1'b1; wq();
      b = {b[6:0], sda_line};
      scl = 1'b0;
    end
    got_q.push_back(b);
    m_low = give_ack; wq();
    scl = 1'b1; wq();
    scl = 1'b0;
    m_low = 1'b0; wq();
  endtask

  // driver: expectation for one read byte at the model pointer
  task automatic expect_rd(input string tag);
    exp_q.push_back(mdl[mptr]);
    tag_q.push_back(tag);
    mptr = (mptr + 1) % N;
  endtask

  task automatic hdr(input bit rd, input string tag);
    bit a;
    send_byte({DEV, rd}, a);
    chk(a, tag, a, 1);
  endtask

  task automatic wr_seq(input logic [7:0] sub, input int n,
                        input logic [31:0] data, input string tag);
    bit a;
    bus_start();
    hdr(1'b0, "R2");
    send_byte(sub, a);
    chk(a, "R4", a, 1);
    mptr = sub % N;
    for (int i = 0; i < n; i++) begin
      send_byte(data[31-8*i -: 8], a);
      chk(a, tag, a, 1);
      mdl[mptr] = data[31-8*i -: 8];
      mptr = (mptr + 1) % N;
    end
    bus_stop();
  endtask

  task automatic rd_cur(input int n, input string tag);
    bus_start();
    hdr(1'b1, "R2");
    for (int i = 0; i < n; i++) begin
      expect_rd(tag);
      recv_byte(i < n - 1);
    end
    bus_stop();
  endtask

  task automatic rd_rand(input logic [7:0] sub, input int n, input string tag);
    bit a;
    bus_start();
    hdr(1'b0, "R2");
    send_byte(sub, a);
    chk(a, "R4", a, 1);
    mptr = sub % N;
    bus_start();             // repeated start
    hdr(1'b1, "R8");
    for (int i = 0; i < n; i++) begin
      expect_rd(tag);
      recv_byte(i < n - 1);
    end
    bus_stop();
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit a;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    mptr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: released line and zero bank after reset
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    rd_cur(2, "R1");

    // R4: burst write starting at index 3
    wr_seq(8'h03, 3, 32'hA1B2C300, "R4");
    // R7: current read continues after the write burst
    rd_cur(1, "R7");
    // R8: random read from the loaded index
    rd_rand(8'h03, 3, "R8");
    // R7: multi-byte current read with controller acks
    rd_cur(3, "R7");

    // R6: write burst crossing the top of the bank, read back across it
    wr_seq(8'h08, 4, 32'h11223344, "R6");
    rd_rand(8'h08, 4, "R6");

    // R5: indices above the bank are reduced modulo NREGS
    wr_seq(8'h0C, 1, 32'h5A000000, "R5");
    rd_rand(8'h0D, 1, "R5");
    rd_rand(8'h02, 1, "R5");

    // R3: wrong address, trailing bytes ignored, pointer intact
    bus_start();
    send_byte({7'h11, 1'b0}, a);
    chk(!a, "R3", a, 0);
    send_byte(8'h05, a);
    chk(!a, "R3", a, 0);
    send_byte(8'hEE, a);
    chk(!a, "R3", a, 0);
    bus_stop();
    rd_cur(2, "R3");

    // R9: after a read nack, further clocks are ignored until a start
    bus_start();
    hdr(1'b1, "R2");
    expect_rd("R9");
    recv_byte(1'b0);
    send_byte(8'h00, a);
    chk(!a, "R9", a, 0);
    bus_start();
    hdr(1'b1, "R9");
    expect_rd("R9");
    recv_byte(1'b0);
    bus_stop();
    drain();
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);

    // R1: reset in mid-run clears the bank
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) mdl[i] = '0;
    mptr = 0;
    rd_rand(8'h03, 2, "R1");
    rd_rand(8'h08, 3, "R1");

    drain();
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule